// File: doc/BRIEF.md
# Timer Output Compare Channel

This block compares one of two free-running 16-bit time-base counters against a primary and a secondary compare value. It drives a single output pin according to a 3-bit mode code. Three single-match modes set the pin, clear the pin or toggle it when the counter equals the primary value. Two dual-match modes raise the pin on a primary match and drop it on a secondary match, either once or on every counter period.

Each change of pin state caused by a compare event is followed by a sticky interrupt flag, which software clears with a one-cycle strobe. In the dual modes only the falling edge counts as such an event. The timers, their prescalers and their period logic sit outside the block. The block sees only the counter values. A compare value that the counter never reaches, because it wraps at a lower period, simply never matches.

All ports are plain level or strobe signals. Nothing flows as a stream, so there is no valid/ready handshake.

Top module: `oc_channel`

## Requirements
- R1: In mode 3'b001 the pin is low on entry to the mode. It goes high in the cycle after the selected counter first equals the primary compare value, and later matches leave it high.
- R2: In mode 3'b010 the pin is high on entry to the mode. It goes low in the cycle after the first primary match and stays low.
- R3: In mode 3'b011 the pin is low on entry to the mode and inverts in the cycle after every primary match.
- R4: In the single-match modes the interrupt flag rises two cycles after the pin change caused by a match, which is three cycles after the match cycle.
- R5: In mode 3'b100 the pin rises after a primary match and falls after the next secondary match. From then on it stays low. The flag rises two cycles after that fall, and a rising edge never sets the flag.
- R6: In mode 3'b101 the rise and fall repeat on every counter period with no re-arming, and every fall sets the flag two cycles later.
- R7: A compare value above the counter's wrap value never matches. A primary value that is out of range gives no rising edge, and a secondary value that is out of range gives no falling edge and no interrupt.
- R8: When `tmr_sel` is 0, `tmr_a` is compared. When `tmr_sel` is 1, `tmr_b` is compared. The counter that is not selected has no effect.
- R9: Mode 3'b000 and the unused codes 3'b110 and 3'b111 hold the pin low and never set the flag.
- R10: In the cycle in which the mode value differs from the previous one, matches are ignored, events still pending toward the flag are discarded, and the pin takes the entry level of the new mode in the next cycle.
- R11: The flag stays set until a `flag_clr` strobe, which clears it in the next cycle. When a set and a clear arrive in the same cycle, the set wins.
- R12: After reset the pin and the flag are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_a | input | 16 | Time-base counter A value |
| tmr_b | input | 16 | Time-base counter B value |
| tmr_sel | input | 1 | Counter select: 0 = A, 1 = B |
| mode | input | 3 | Channel mode code |
| cmp_pri | input | 16 | Primary compare value |
| cmp_sec | input | 16 | Secondary compare value |
| flag_clr | input | 1 | One-cycle interrupt flag clear strobe |
| pin | output | 1 | Compare output level |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The pin is due one clock edge after the cycle in which the counter holds the matching value. The flag is due two edges after that. The bench drives each cycle's inputs on the falling clock edge and samples on the next falling edge, so each sample shows exactly one new rising edge's result. The expected pin after edge k therefore folds in the matches of cycles 1 to k. The flag is expected from edge e+2 on, where e is the first event cycle. Directed sequences place a mode change inside that two-edge window, and they place a clear strobe both on the edge where the flag sets and on a later edge.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [2:0] {
    OC_OFF   = 3'b000,
    OC_SET   = 3'b001,
    OC_CLR   = 3'b010,
    OC_TGL   = 3'b011,
    OC_ONE   = 3'b100,
    OC_TRAIN = 3'b101,
    OC_RSV6  = 3'b110,
    OC_RSV7  = 3'b111
  } oc_mode_e;

  // Pin level applied on entry to a mode
  function automatic logic oc_entry_level(input oc_mode_e m);
    return (m == OC_CLR);
  endfunction

  // Modes that use both compare values
  function automatic logic oc_is_dual(input oc_mode_e m);
    return (m == OC_ONE) || (m == OC_TRAIN);
  endfunction

endpackage

// File: rtl/oc_match.sv
module oc_match #(
  parameter int W     = 16,
  parameter int NTMR  = 2,
  localparam int SW   = (NTMR > 1) ? $clog2(NTMR) : 1
) (
  input  logic [NTMR*W-1:0] tmr_flat,
  input  logic [SW-1:0]     sel,
  input  logic [W-1:0]      cmp_pri,
  input  logic [W-1:0]      cmp_sec,
  output logic              hit_pri,
  output logic              hit_sec
);

  logic [W-1:0] tmr_arr [NTMR];
  logic [W-1:0] tmr_cur;

  genvar gi;
  generate
    for (gi = 0; gi < NTMR; gi++) begin : g_unpack
      assign tmr_arr[gi] = tmr_flat[gi*W +: W];
    end
  endgenerate

  always_comb begin
    tmr_cur = tmr_arr[0];
    for (int i = 0; i < NTMR; i++) begin
      if (sel == SW'(i)) tmr_cur = tmr_arr[i];
    end
  end

  assign hit_pri = (tmr_cur == cmp_pri);
  assign hit_sec = (tmr_cur == cmp_sec);

endmodule

// File: rtl/oc_pin_fsm.sv
module oc_pin_fsm
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       hit_pri,
  input  logic       hit_sec,
  output logic       pin,
  output logic       evt,
  output logic       mode_chg
);

  oc_mode_e mode_q;
  oc_mode_e mode_cur;
  logic     pin_q, pin_n;
  logic     done_q, done_n;

  assign mode_cur = oc_mode_e'(mode);
  assign mode_chg = (mode_cur != mode_q);

  always_comb begin
    pin_n  = pin_q;
    done_n = done_q;
    evt    = 1'b0;
    if (mode_chg) begin
      pin_n  = oc_entry_level(mode_cur);
      done_n = 1'b0;
    end else begin
      unique case (mode_cur)
        OC_SET: begin
          if (hit_pri && !pin_q) begin
            pin_n = 1'b1;
            evt   = 1'b1;
          end
        end
        OC_CLR: begin
          if (hit_pri && pin_q) begin
            pin_n = 1'b0;
            evt   = 1'b1;
          end
        end
        OC_TGL: begin
          if (hit_pri) begin
            pin_n = !pin_q;
            evt   = 1'b1;
          end
        end
        OC_ONE, OC_TRAIN: begin
          if (!done_q) begin
            if (!pin_q && hit_pri) begin
              pin_n = 1'b1;
            end else if (pin_q && hit_sec) begin
              pin_n  = 1'b0;
              evt    = 1'b1;
              done_n = (mode_cur == OC_ONE);
            end
          end
        end
        default: begin
          pin_n  = 1'b0;
          done_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= OC_OFF;
      pin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      mode_q <= mode_cur;
      pin_q  <= pin_n;
      done_q <= done_n;
    end
  end

  assign pin = pin_q;

endmodule

// File: rtl/oc_irq.sv
module oc_irq #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic flush,
  input  logic flag_clr,
  output logic irq_set,
  output logic irq_flag
);

  logic [DLY-1:0] pipe_q;
  logic           flag_q;

  genvar gi;
  generate
    for (gi = 0; gi < DLY; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     pipe_q[0] <= 1'b0;
          else if (flush) pipe_q[0] <= 1'b0;
          else            pipe_q[0] <= evt;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     pipe_q[gi] <= 1'b0;
          else if (flush) pipe_q[gi] <= 1'b0;
          else            pipe_q[gi] <= pipe_q[gi-1];
        end
      end
    end
  endgenerate

  assign irq_set = pipe_q[DLY-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (irq_set)  flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign irq_flag = flag_q;

endmodule

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int W       = 16,
  parameter int IRQ_DLY = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tmr_a,
  input  logic [W-1:0] tmr_b,
  input  logic         tmr_sel,
  input  logic [2:0]   mode,
  input  logic [W-1:0] cmp_pri,
  input  logic [W-1:0] cmp_sec,
  input  logic         flag_clr,
  output logic         pin,
  output logic         irq_flag
);

  localparam int NTMR = 2;

  logic hit_pri, hit_sec;
  logic evt, mode_chg, irq_set;

  oc_match #(.W(W), .NTMR(NTMR)) u_match (
    .tmr_flat (({tmr_b, tmr_a})),
    .sel      (tmr_sel),
    .cmp_pri  (cmp_pri),
    .cmp_sec  (cmp_sec),
    .hit_pri  (hit_pri),
    .hit_sec  (hit_sec)
  );

  oc_pin_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .hit_pri  (hit_pri),
    .hit_sec  (hit_sec),
    .pin      (pin),
    .evt      (evt),
    .mode_chg (mode_chg)
  );

  oc_irq #(.DLY(IRQ_DLY)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .flush    (mode_chg),
    .flag_clr (flag_clr),
    .irq_set  (irq_set),
    .irq_flag (irq_flag)
  );

endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       flag_clr,
  input logic       pin,
  input logic       irq_flag,
  input logic       hit_pri,
  input logic       mode_chg,
  input logic       irq_set
);

  p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000 || mode == 3'b110 || mode == 3'b111) |=> !pin);

  p_entry_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && mode == 3'b010) |=> pin);

  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b011 && !mode_chg && hit_pri) |=> (pin != $past(pin)));

  p_set_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b001 && !mode_chg && pin) |=> pin);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq_flag);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !irq_set) |=> !irq_flag);

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !irq_set);

endmodule

bind oc_channel oc_channel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .flag_clr (flag_clr),
  .pin      (pin),
  .irq_flag (irq_flag),
  .hit_pri  (hit_pri),
  .mode_chg (mode_chg),
  .irq_set  (irq_set)
);

// File: tb/oc_channel_bench.sv
module oc_channel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr_a = '0;
  logic [15:0] tmr_b = '0;
  logic        tmr_sel = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [15:0] cmp_pri = '0;
  logic [15:0] cmp_sec = '0;
  logic        flag_clr = 1'b0;
  logic        pin;
  logic        irq_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #2 clk = !clk;

  oc_channel u_oc_channel (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_a    (tmr_a),
    .tmr_b    (tmr_b),
    .tmr_sel  (tmr_sel),
    .mode     (mode),
    .cmp_pri  (cmp_pri),
    .cmp_sec  (cmp_sec),
    .flag_clr (flag_clr),
    .pin      (pin),
    .irq_flag (irq_flag)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Counter values for cycle k: selected one wraps at per, the other is shifted
  task automatic drive_cnt(input logic sl, input int k, input int per);
    int own, oth;
    own = k % (per + 1);
    oth = (k + per / 2 + 1) % (per + 1);
    if (sl) begin tmr_b = 16'(own); tmr_a = 16'(oth); end
    else    begin tmr_a = 16'(own); tmr_b = 16'(oth); end
  endtask

  task automatic run_case(input logic [2:0] md, input logic sl,
                          input int pri, input int sec, input int per);
    int pin_e, done_e, first_evt, n, sc;
    bit mp, ms, ev;
    string ptag, ftag;
    case (md)
      3'd1: ptag = "R1";
      3'd2: ptag = "R2";
      3'd3: ptag = "R3";
      3'd4: ptag = "R5";
      default: ptag = "R6";
    endcase
    ftag = (md <= 3'd3) ? "R4" : ptag;
    if (pri > per || (md >= 3'd4 && sec > per)) ptag = "R7";
    else if (sl) ptag = "R8";
    @(negedge clk);
    mode = 3'b000; flag_clr = 1'b1; tmr_sel = sl;
    cmp_pri = 16'(pri); cmp_sec = 16'(sec); tmr_a = '0; tmr_b = '0;
    @(negedge clk);
    @(negedge clk);
    flag_clr = 1'b0; mode = md; drive_cnt(sl, 0, per);
    pin_e = (md == 3'd2) ? 1 : 0;
    done_e = 0; first_evt = -1;
    n = 3 * (per + 1) + 3;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (k > 0) begin
        sc = k % (per + 1);
        mp = (sc == pri); ms = (sc == sec); ev = 1'b0;
        case (md)
          3'd1: if (mp && pin_e == 0) begin pin_e = 1; ev = 1'b1; end
          3'd2: if (mp && pin_e == 1) begin pin_e = 0; ev = 1'b1; end
          3'd3: if (mp) begin pin_e = 1 - pin_e; ev = 1'b1; end
          default: if (done_e == 0) begin
            if (pin_e == 0 && mp) pin_e = 1;
            else if (pin_e == 1 && ms) begin
              pin_e = 0; ev = 1'b1;
              if (md == 3'd4) done_e = 1;
            end
          end
        endcase
        if (ev && first_evt < 0) first_evt = k;
      end
      chk(ptag, "pin", pin, pin_e[0]);
      chk(ftag, "irq_flag", irq_flag, (first_evt >= 0 && k >= first_evt + 2));
      drive_cnt(sl, k + 1, per);
    end
  endtask

  task automatic put(input logic [2:0] md, input logic [15:0] ta, input logic clr);
    mode = md; tmr_a = ta; flag_clr = clr;
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int pris[5];
    int secs[3];
    int pers[2];
    pris = '{0, 2, 5, 9, 11};
    secs = '{3, 6, 11};
    pers = '{5, 9};
    tmr_b = 16'd500;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "pin in reset", pin, 1'b0);
    chk("R12", "flag in reset", irq_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "pin after reset", pin, 1'b0);
    chk("R12", "flag after reset", irq_flag, 1'b0);

    // R9: off and unused codes with the counter matching every cycle
    cmp_pri = 16'd7; cmp_sec = 16'd7; tmr_sel = 1'b0;
    foreach (pris[i]) begin end
    for (int c = 0; c < 3; c++) begin
      logic [2:0] md;
      md = (c == 0) ? 3'b000 : ((c == 1) ? 3'b110 : 3'b111);
      put(md, 16'd7, 1'b0);
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk("R9", "pin", pin, 1'b0);
        chk("R9", "irq_flag", irq_flag, 1'b0);
      end
    end

    // R10: mode change inside the interrupt window discards it
    put(3'b000, 16'd100, 1'b1);
    @(negedge clk);
    @(negedge clk);
    put(3'b011, 16'd100, 1'b0);      // cycle 0
    @(negedge clk);
    put(3'b011, 16'd7, 1'b0);        // cycle 1: match
    @(negedge clk);
    chk("R3", "pin after match", pin, 1'b1);
    put(3'b010, 16'd100, 1'b0);      // cycle 2: mode change
    @(negedge clk);
    chk("R10", "entry level", pin, 1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10", "flag discarded", irq_flag, 1'b0);
    end

    // R11: set and clear together, stickiness, later clear
    put(3'b000, 16'd100, 1'b1);
    @(negedge clk);
    @(negedge clk);
    put(3'b011, 16'd100, 1'b0);      // cycle 0
    @(negedge clk);
    put(3'b011, 16'd7, 1'b0);        // cycle 1: match
    @(negedge clk);
    put(3'b011, 16'd100, 1'b0);      // cycle 2
    @(negedge clk);
    chk("R11", "flag before set", irq_flag, 1'b0);
    put(3'b011, 16'd100, 1'b1);      // cycle 3: set and clear together
    @(negedge clk);
    chk("R11", "set wins", irq_flag, 1'b1);
    put(3'b011, 16'd100, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11", "sticky", irq_flag, 1'b1);
    end
    put(3'b011, 16'd100, 1'b1);
    @(negedge clk);
    chk("R11", "cleared", irq_flag, 1'b0);
    put(3'b011, 16'd100, 1'b0);
    @(negedge clk);
    chk("R11", "stays clear", irq_flag, 1'b0);

    // Sweep of compare modes, select, compare values and wrap values
    for (int m = 1; m <= 5; m++)
      for (int s = 0; s < 2; s++)
        foreach (pers[pi])
          foreach (pris[ai])
            foreach (secs[bi])
              if (m >= 4 || bi == 0)
                run_case(3'(m), s[0], pris[ai], secs[bi], pers[pi]);

    finish_run();
  end

endmodule